// File: doc/BRIEF.md
# Programmable Limit Interval Timer

This block is a 32-bit interval timer that a processor controls through a small register port. It holds three registers: a running count, a control word and a limit. Every clock the count moves up by one. When it has reached the limit, the next step loads zero instead. If interrupts are enabled, that same step raises a pending flag, and the interrupt output stays high while the flag is set. The count can be told to stop while the processor reports that it is halted. Any write to the control word clears the pending flag.

The register port has no flow control. A write takes effect at the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr` and the current register state, so there is no back-pressure to manage. A parameter gives the base address: the count register sits at the base, control at base+1 and limit at base+2. This lets several instances share one bus. Their read data is ORed, because an instance that is not addressed drives zero. A typical system uses one instance at 0x21 as an event timer and one at 0x100 as a wrapping free-running counter.

Top module: `interval_timer`

## Requirements
- R1: After synchronous active-low reset the count is 0, the limit is 0xFFFFFFFF, the control word reads 0 and `irq` is low.
- R2: While counting is allowed, the count increases by one on every clock.
- R3: When the count equals the limit at a counting edge, the count becomes 0 at that edge.
- R4: Control bit 0 is the interrupt enable. A wrap with the enable at 1 sets the pending flag at the same edge, and `irq` is high exactly while the flag is set. A wrap with the enable at 0 leaves the flag unchanged.
- R5: Control bit 1 is the halt-stall bit. When it is 1 and `cpu_halted` is 1, the count holds its value. When it is 0, `cpu_halted` has no effect.
- R6: A write to the control address clears the pending flag, whatever the data is.
- R7: If a wrap with the enable at 1 and a control write fall on the same edge, the flag ends up set.
- R8: A write to the count address loads the written value. It takes priority over the increment in that cycle and prevents a wrap, and therefore any flag set, in that cycle.
- R9: Reading the control address returns the enable in bit 0, the halt-stall bit in bit 1 and the pending flag in bit 3, with all other bits 0. Written bits other than 1:0 are discarded.
- R10: The count, control and limit registers sit at BASE_ADDR, BASE_ADDR+1 and BASE_ADDR+2. Any other address reads 0 and a write to it changes nothing.
- R11: With the limit at 0xFFFFFFFF and the enable at 0, the count wraps from 0xFFFFFFFF to 0 without raising `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, zero when not addressed |
| cpu_halted | input | 1 | Processor halted status |
| irq | output | 1 | Level interrupt, high while pending |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` have defined values whenever `bus_wr` is high, and that `cpu_halted` is a plain level that changes only between edges. The bench drives every input at the falling edge from tasks, so the inputs are always defined and stable around the rising edge. It places two instances at different bases on one bus to cover the address decode, and it times the control write that collides with a wrap by counting edges from a known count value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned SLOT_NUM = 3;
  localparam int unsigned SLOT_COUNT = 0;
  localparam int unsigned SLOT_CTRL  = 1;
  localparam int unsigned SLOT_LIMIT = 2;
  localparam int unsigned IE_BIT   = 0;
  localparam int unsigned NH_BIT   = 1;
  localparam int unsigned PEND_BIT = 3;
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BASE_ADDR = 32'h21
) (
  input  logic [ADDR_W-1:0]            addr,
  output logic [tmr_pkg::SLOT_NUM-1:0] hit
);
  for (genvar i = 0; i < tmr_pkg::SLOT_NUM; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE_ADDR + i);
    assign hit[i] = (addr == SLOT_ADDR);
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              advance,
  input  logic [DATA_W-1:0] limit,
  output logic [DATA_W-1:0] count,
  output logic              wrap
);
  logic at_limit;
  assign at_limit = (count == limit);
  assign wrap     = advance && !load && at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (advance) begin
      count <= at_limit ? '0 : count + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              limit_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wrap,
  output logic              ie,
  output logic              nh,
  output logic              pending,
  output logic [DATA_W-1:0] limit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie      <= 1'b0;
      nh      <= 1'b0;
      pending <= 1'b0;
      limit   <= '1;
    end else begin
      if (ctrl_we) begin
        ie <= wdata[tmr_pkg::IE_BIT];
        nh <= wdata[tmr_pkg::NH_BIT];
      end
      if (limit_we) limit <= wdata;
      if (wrap && ie)   pending <= 1'b1;
      else if (ctrl_we) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BASE_ADDR = 32'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cpu_halted,
  output logic              irq
);
  import tmr_pkg::*;

  logic [SLOT_NUM-1:0] hit;
  logic [DATA_W-1:0]   count_q, limit_q;
  logic                ie_q, nh_q, pend_q, wrap_evt, advance;

  tmr_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(bus_addr), .hit(hit)
  );

  assign advance = !(nh_q && cpu_halted);

  tmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(bus_wr && hit[SLOT_COUNT]), .load_val(bus_wdata),
    .advance(advance), .limit(limit_q),
    .count(count_q), .wrap(wrap_evt)
  );

  tmr_ctrl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(bus_wr && hit[SLOT_CTRL]),
    .limit_we(bus_wr && hit[SLOT_LIMIT]),
    .wdata(bus_wdata), .wrap(wrap_evt),
    .ie(ie_q), .nh(nh_q), .pending(pend_q), .limit(limit_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit[SLOT_COUNT]) bus_rdata = count_q;
    if (hit[SLOT_LIMIT]) bus_rdata = limit_q;
    if (hit[SLOT_CTRL]) begin
      bus_rdata[IE_BIT]   = ie_q;
      bus_rdata[NH_BIT]   = nh_q;
      bus_rdata[PEND_BIT] = pend_q;
    end
  end

  assign irq = pend_q;
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BASE_ADDR = 32'h21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              cpu_halted,
  input logic              irq,
  input logic [DATA_W-1:0] count_q,
  input logic              ie_q,
  input logic              nh_q,
  input logic              wrap_evt
);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE_ADDR + 1);

  logic wr_cnt, wr_ctrl, may_count;
  assign wr_cnt    = bus_wr && (bus_addr == A_CNT);
  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign may_count = !(nh_q && cpu_halted);

  assert_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    may_count && !wr_cnt && !wrap_evt |=> count_q == $past(count_q) + 1'b1);
  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> count_q == '0);
  assert_irq_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt && ie_q |=> irq);
  assert_irq_needs_ie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && !(wrap_evt && ie_q) |=> !irq);
  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nh_q && cpu_halted && !wr_cnt |=> $stable(count_q));
  assert_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && !(wrap_evt && ie_q) |=> !irq);
  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> count_q == $past(bus_wdata));
  assert_ctrl_fmt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == A_CTRL |-> bus_rdata[DATA_W-1:4] == '0 && bus_rdata[2] == 1'b0);
endmodule

bind interval_timer interval_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_halted(cpu_halted),
  .irq(irq), .count_q(count_q), .ie_q(ie_q), .nh_q(nh_q), .wrap_evt(wrap_evt)
);

// File: tb/interval_timer_test.sv
`timescale 1ns/1ps
module interval_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        cpu_halted = 1'b0;
  logic [31:0] rd0, rd1, rdata;
  logic        irq0, irq1;

  always #5 clk = ~clk;

  interval_timer #(.ADDR_W(12), .DATA_W(32), .BASE_ADDR(32'h21)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd0), .cpu_halted(cpu_halted), .irq(irq0));
  interval_timer #(.ADDR_W(12), .DATA_W(32), .BASE_ADDR(32'h100)) uut1 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd1), .cpu_halted(cpu_halted), .irq(irq1));
  assign rdata = rd0 | rd1;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural model of both timers
  int unsigned base [2] = '{32'h21, 32'h100};
  logic [31:0] m_cnt [2];
  logic [31:0] m_lim [2];
  bit m_ie [2], m_nh [2], m_pend [2];

  task automatic model_reset();
    for (int t = 0; t < 2; t++) begin
      m_cnt[t] = 0; m_lim[t] = 32'hFFFF_FFFF;
      m_ie[t] = 0; m_nh[t] = 0; m_pend[t] = 0;
    end
  endtask

  task automatic model_step();
    for (int t = 0; t < 2; t++) begin
      bit wc, wk, wl, stepping, wrapped;
      wc = bus_wr && (bus_addr == 12'(base[t]));
      wk = bus_wr && (bus_addr == 12'(base[t] + 1));
      wl = bus_wr && (bus_addr == 12'(base[t] + 2));
      stepping = !(m_nh[t] && cpu_halted);
      wrapped = 0;
      if (wc) m_cnt[t] = bus_wdata;
      else if (stepping) begin
        if (m_cnt[t] == m_lim[t]) begin wrapped = 1; m_cnt[t] = 0; end
        else m_cnt[t] = m_cnt[t] + 1;
      end
      if (wrapped && m_ie[t]) m_pend[t] = 1;
      else if (wk) m_pend[t] = 0;
      if (wk) begin m_ie[t] = bus_wdata[0]; m_nh[t] = bus_wdata[1]; end
      if (wl) m_lim[t] = bus_wdata;
    end
  endtask

  function automatic logic [31:0] model_read(logic [11:0] a);
    for (int t = 0; t < 2; t++) begin
      if (a == 12'(base[t]))     return m_cnt[t];
      if (a == 12'(base[t] + 1)) return {28'd0, m_pend[t], 1'b0, m_nh[t], m_ie[t]};
      if (a == 12'(base[t] + 2)) return m_lim[t];
    end
    return 32'd0;
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("rdata", rdata, model_read(bus_addr));
    check("irq0", {31'd0, irq0}, {31'd0, m_pend[0]});
    check("irq1", {31'd0, irq1}, {31'd0, m_pend[1]});
  endtask

  // one clock: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic cyc(bit wr, logic [11:0] a, logic [31:0] d, bit halt);
    bus_wr = wr; bus_addr = a; bus_wdata = d; cpu_halted = halt;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(logic [11:0] a, int n, bit halt = 0);
    for (int i = 0; i < n; i++) cyc(0, a, 0, halt);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset values visible before release
    cur_req = "R1";
    bus_addr = 12'h22; #1 check("ctrl after reset", rdata, 32'd0);
    bus_addr = 12'h23; #1 check("limit after reset", rdata, 32'hFFFF_FFFF);
    bus_addr = 12'h21; #1 check("count after reset", rdata, 32'd0);
    check("irq after reset", {31'd0, irq0}, 32'd0);
    rst_n = 1'b1;
    idle(12'h21, 3);

    cur_req = "R2";
    cyc(1, 12'h21, 32'd10, 0);
    idle(12'h21, 5);

    cur_req = "R10";
    cyc(1, 12'h100, 32'd500, 0);
    idle(12'h21, 2);
    cyc(1, 12'h050, 32'hFFFF, 0);
    idle(12'h050, 3);
    idle(12'h024, 2);
    idle(12'h100, 3);

    cur_req = "R3";
    cyc(1, 12'h23, 32'd5, 0);
    cyc(1, 12'h21, 32'd0, 0);
    idle(12'h21, 14);

    cur_req = "R4";
    idle(12'h22, 8);
    cyc(1, 12'h22, 32'h1, 0);
    idle(12'h22, 8);

    cur_req = "R6";
    cyc(1, 12'h22, 32'h1, 0);
    idle(12'h22, 5);
    cyc(1, 12'h22, 32'h0, 0);
    idle(12'h22, 2);

    cur_req = "R7";
    cyc(1, 12'h22, 32'h1, 0);
    cyc(1, 12'h21, 32'd4, 0);
    cyc(0, 12'h21, 0, 0);
    cyc(1, 12'h22, 32'h1, 0);
    check("pending kept on collision", {31'd0, irq0}, 32'd1);
    idle(12'h22, 2);

    cur_req = "R8";
    cyc(1, 12'h22, 32'h1, 0);
    cyc(1, 12'h21, 32'd5, 0);
    cyc(1, 12'h21, 32'd2, 0);
    check("no wrap under load", {31'd0, irq0}, 32'd0);
    idle(12'h21, 3);

    cur_req = "R5";
    cyc(1, 12'h22, 32'h3, 0);
    cyc(1, 12'h23, 32'd1000, 0);
    idle(12'h21, 5, 1);
    idle(12'h21, 2, 0);
    cyc(1, 12'h22, 32'h1, 0);
    idle(12'h21, 5, 1);

    cur_req = "R9";
    cyc(1, 12'h22, 32'hFFFF_FFF2, 0);
    idle(12'h22, 3);
    cyc(1, 12'h23, 32'd3, 0);
    cyc(1, 12'h22, 32'hFFFF_FFF1, 0);
    idle(12'h22, 6);

    cur_req = "R11";
    cyc(1, 12'h100, 32'hFFFF_FFFC, 0);
    idle(12'h100, 6);
    check("free-running no irq", {31'd0, irq1}, 32'd0);

    done = 1;
    finish_run();
  end
endmodule